// File: doc/BRIEF.md
# Per-Block Lock State Controller

This controller keeps a volatile protection state for every block of a flash-style memory array. Software changes that state with two-cycle bus write sequences. The first write carries a setup code. The second write carries a confirm code, which picks lock, unlock or lock-down, and an address whose upper bits select the target block. Any other code in the second write abandons the sequence and changes nothing.

Each block is open, locked or locked-down. A write-protect level input decides whether a locked-down block may be reopened. A hardware reset, which also stands for power-up, puts every block in the locked state. A query address returns the status bits of the selected block and a program/erase permission flag. The flash array and its program and erase algorithms sit next to this block and consult the permission flag.

Top module: `blk_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it returns high, every block reads status 01 (locked) and `q_allow` is 0. This includes blocks that were locked-down or open before the reset.
- R2: A command is a write with `wr_data` = 0x5A (setup) followed by a second write. The block state changes at the clock edge that captures the second write. The setup write alone changes nothing. A confirm code written without a preceding setup has no effect.
- R3: The second-write codes are 0x11 for lock, 0x22 for unlock and 0x33 for lock-down. Any other value abandons the sequence with no state change, and the sequencer returns to idle, so a following lone confirm write is ignored.
- R4: The target block index is `wr_addr[7:5]` of the second write. The lower address bits are ignored, and blocks other than the target keep their state.
- R5: `q_status` for the block `q_addr[7:5]` reads as {lock-down bit, lock bit}: 00 means open, 01 locked and 11 locked-down. The value 10 never occurs.
- R6: `q_allow` is 1 exactly when the queried block is open (status 00).
- R7: Lock moves an open block to locked. Lock on a locked-down block leaves it locked-down.
- R8: Lock-down moves any block to locked-down, whatever the level of `wp_level`.
- R9: Unlock moves a locked block to open. A locked-down block moves to open only when `wp_level` is 1; when `wp_level` is 0 it stays locked-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset / power-up |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 8 | Bus write address; upper bits select the block |
| wr_data | input | 8 | Bus write data: setup or confirm code |
| wp_level | input | 1 | Write-protect level; 1 allows unlocking locked-down blocks |
| q_addr | input | 8 | Query address; upper bits select the block |
| q_status | output | 2 | {lock-down bit, lock bit} of the queried block |
| q_allow | output | 1 | Program/erase permitted for the queried block |

## Verification
The assertions assume that every write strobe lasts exactly one cycle with known address and data. They also assume that `wp_level` is settled at the edge that captures a confirm write, because the lock-down hold property samples the level at that edge. The bench changes all inputs on the falling edge and drops `wr_en` after each write, so every sampled value is stable and defined. Reset is asserted from time zero, which gives the reset property a defined first sample.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CODE_SETUP  = 8'h5A;
  localparam logic [CMD_W-1:0] CODE_LOCK   = 8'h11;
  localparam logic [CMD_W-1:0] CODE_UNLOCK = 8'h22;
  localparam logic [CMD_W-1:0] CODE_PIN    = 8'h33;

  // block state: bit1 = lock-down, bit0 = lock
  localparam logic [1:0] ST_OPEN   = 2'b00;
  localparam logic [1:0] ST_LOCKED = 2'b01;
  localparam logic [1:0] ST_PINNED = 2'b11;

  typedef enum logic [1:0] {OP_LOCK = 2'd0, OP_UNLOCK = 2'd1, OP_PIN = 2'd2} lk_op_e;

  // {valid, op} for a second-cycle code
  function automatic logic [2:0] lk_decode(input logic [CMD_W-1:0] code);
    case (code)
      CODE_LOCK:   return {1'b1, OP_LOCK};
      CODE_UNLOCK: return {1'b1, OP_UNLOCK};
      CODE_PIN:    return {1'b1, OP_PIN};
      default:     return 3'b000;
    endcase
  endfunction

  function automatic logic [1:0] lk_next(input logic [1:0] cur, input logic [1:0] op,
                                         input logic wp);
    case (op)
      OP_LOCK:   return (cur == ST_PINNED) ? ST_PINNED : ST_LOCKED;
      OP_UNLOCK: return (cur == ST_PINNED && !wp) ? ST_PINNED : ST_OPEN;
      OP_PIN:    return ST_PINNED;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/lk_cmd_seq.sv
module lk_cmd_seq
  import lock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  output logic              armed,
  output logic              fire,
  output logic [1:0]        fire_op,
  output logic [IDX_W-1:0]  fire_idx
);
  logic [2:0] dec;
  logic       arm_next;

  assign dec      = lk_decode(wr_data);
  assign fire     = armed && wr_en && dec[2];
  assign fire_op  = dec[1:0];
  assign fire_idx = wr_addr[ADDR_W-1 -: IDX_W];

  always_comb begin
    arm_next = armed;
    if (wr_en) begin
      if (armed) arm_next = 1'b0;
      else       arm_next = (wr_data == CODE_SETUP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= arm_next;
  end
endmodule

// File: rtl/lk_state_bank.sv
module lk_state_bank
  import lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int IDX_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [1:0]              fire_op,
  input  logic [IDX_W-1:0]        fire_idx,
  input  logic                    wp_level,
  output logic [2*NUM_BLOCKS-1:0] state_flat
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [1:0] st_q;
    logic       hit;
    assign hit = fire && (int'(fire_idx) == b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= ST_LOCKED;
      else if (hit) st_q <= lk_next(st_q, fire_op, wp_level);
    end
    assign state_flat[2*b +: 2] = st_q;
  end
endmodule

// File: rtl/lk_query.sv
module lk_query
  import lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int IDX_W      = 3
) (
  input  logic [2*NUM_BLOCKS-1:0] state_flat,
  input  logic [IDX_W-1:0]        q_idx,
  output logic [1:0]              q_status,
  output logic                    q_allow
);
  always_comb begin
    q_status = ST_LOCKED;
    for (int b = 0; b < NUM_BLOCKS; b++)
      if (int'(q_idx) == b) q_status = state_flat[2*b +: 2];
  end
  assign q_allow = (q_status == ST_OPEN);
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wp_level,
  input  logic [ADDR_W-1:0] q_addr,
  output logic [1:0]        q_status,
  output logic              q_allow
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);

  logic                    seq_armed;
  logic                    cmd_fire;
  logic [1:0]              cmd_op;
  logic [IDX_W-1:0]        cmd_idx;
  logic [2*NUM_BLOCKS-1:0] state_flat;

  lk_cmd_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .armed(seq_armed), .fire(cmd_fire), .fire_op(cmd_op), .fire_idx(cmd_idx)
  );

  lk_state_bank #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .fire(cmd_fire), .fire_op(cmd_op), .fire_idx(cmd_idx),
    .wp_level(wp_level), .state_flat(state_flat)
  );

  lk_query #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) query_i (
    .state_flat(state_flat), .q_idx(q_addr[ADDR_W-1 -: IDX_W]),
    .q_status(q_status), .q_allow(q_allow)
  );
endmodule

// File: rtl/lk_checker.sv
module lk_checker #(
  parameter int NUM_BLOCKS = 8,
  parameter int IDX_W      = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic                    wp_level,
  input logic                    seq_armed,
  input logic                    cmd_fire,
  input logic [IDX_W-1:0]        cmd_idx,
  input logic [2*NUM_BLOCKS-1:0] state_flat
);
  localparam logic [2*NUM_BLOCKS-1:0] ALL_LOCKED = {NUM_BLOCKS{2'b01}};

  // R1
  reset_locked_chk: assert property (@(posedge clk) !rst_n |=> state_flat == ALL_LOCKED);

  // R2
  fire_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> seq_armed);

  // R3
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_armed && wr_en) |=> !seq_armed);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_chk
    // R5
    encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_flat[2*b +: 2] != 2'b10);
    // R4
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_fire && int'(cmd_idx) == b) |=> $stable(state_flat[2*b +: 2]));
    // R9
    pinned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_flat[2*b +: 2] == 2'b11 && !wp_level) |=> state_flat[2*b +: 2] == 2'b11);
  end
endmodule

bind blk_lock_ctrl lk_checker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wp_level(wp_level), .seq_armed(seq_armed),
  .cmd_fire(cmd_fire), .cmd_idx(cmd_idx), .state_flat(state_flat)
);

// File: tb/blk_lock_ctrl_tb_top.sv
module blk_lock_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wp_level = 1'b0;
  logic [7:0] q_addr = '0;
  logic [1:0] q_status;
  logic       q_allow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  blk_lock_ctrl dut_i (.*);

  // {wp, first code, second code, block, expected status, expected allow}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'h5A, 8'h22, 3'd0, 2'b00, 1'b1},  // R9 unlock locked
    {1'b0, 8'h5A, 8'h11, 3'd0, 2'b01, 1'b0},  // R7 lock open
    {1'b0, 8'h5A, 8'h22, 3'd3, 2'b00, 1'b1},  // R9
    {1'b0, 8'h5A, 8'h33, 3'd3, 2'b11, 1'b0},  // R8 open -> locked-down
    {1'b0, 8'h5A, 8'h22, 3'd3, 2'b11, 1'b0},  // R9 wp low blocks unlock
    {1'b0, 8'h5A, 8'h11, 3'd3, 2'b11, 1'b0},  // R7 lock keeps locked-down
    {1'b0, 8'h5A, 8'h44, 3'd2, 2'b01, 1'b0},  // R3 bad confirm
    {1'b0, 8'h77, 8'h22, 3'd2, 2'b01, 1'b0},  // R2 bad setup
    {1'b1, 8'h5A, 8'h22, 3'd3, 2'b00, 1'b1},  // R9 wp high releases
    {1'b1, 8'h5A, 8'h33, 3'd7, 2'b11, 1'b0},  // R8 with wp high
    {1'b1, 8'h5A, 8'h22, 3'd5, 2'b00, 1'b1},  // R9
    {1'b0, 8'h5A, 8'h22, 3'd6, 2'b00, 1'b1}   // R9
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic query(input logic [2:0] blk, output logic [1:0] st, output logic al);
    q_addr = {blk, 5'h07};
    #1;
    st = q_status; al = q_allow;
  endtask

  initial begin
    logic [1:0] st;
    logic       al;
    repeat (3) @(negedge clk);
    check("R1 status during reset", q_status, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      query(3'(b), st, al);
      check("R1 status after reset", st, 2'b01);
      check("R1 allow after reset", {1'b0, al}, 2'b00);
    end

    for (int i = 0; i < NV; i++) begin
      wp_level = VEC[i][22];
      bus_write(8'h00, VEC[i][21:14]);
      bus_write({VEC[i][5:3], 5'h0B}, VEC[i][13:6]);
      query(VEC[i][5:3], st, al);
      check($sformatf("R5 table %0d status", i), st, VEC[i][2:1]);
      check($sformatf("R6 table %0d allow", i), {1'b0, al}, {1'b0, VEC[i][0]});
    end
    wp_level = 1'b0;

    query(3'd0, st, al); check("R7 block0 relocked", st, 2'b01);
    query(3'd7, st, al); check("R8 block7 locked-down", st, 2'b11);
    query(3'd3, st, al); check("R9 block3 open", st, 2'b00);
    query(3'd1, st, al); check("R4 block1 untouched", st, 2'b01);
    query(3'd4, st, al); check("R4 block4 untouched", st, 2'b01);

    // R3: abandoned sequence, then lone unlock must be ignored
    bus_write(8'h00, 8'h5A);
    bus_write(8'h20, 8'h44);
    bus_write(8'h20, 8'h22);
    query(3'd1, st, al); check("R3 idle after bad confirm", st, 2'b01);

    // R2: lone confirm, then setup-only, then completion
    bus_write(8'h80, 8'h33);
    query(3'd4, st, al); check("R2 lone confirm ignored", st, 2'b01);
    bus_write(8'hC0, 8'h5A);
    query(3'd6, st, al); check("R2 setup alone no change", st, 2'b00);
    bus_write(8'hC1, 8'h11);
    query(3'd6, st, al); check("R2 change on second write", st, 2'b01);

    // R1: reset drops lock-down and relocks open blocks
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    query(3'd7, st, al); check("R1 locked-down back to locked", st, 2'b01);
    query(3'd3, st, al); check("R1 open back to locked", st, 2'b01);
    check("R6 allow after reset", {1'b0, al}, 2'b00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule